// File: doc/BRIEF.md
# Accumulator ALU with Five Status Flags

This block is the arithmetic core of a small 8-bit processor datapath. It holds an accumulator, a hidden operand register and a five-bit status register. Software-visible data arrives on one operand byte. A write strobe parks that byte in the hidden operand register. An execute strobe then applies the selected operation between the accumulator, or the hidden register alone for the increment and decrement variants, and that stored operand.

All operations are register-to-register and complete in one clock. A result written on the execute edge is visible at the outputs after that edge, together with the new flags. The controls are plain strobes with no back-pressure: the block accepts one write and one execute in every cycle. When the write and the execute strobes fall in the same cycle, the execute uses the operand that was stored before that edge, and the new byte becomes visible for the next operation.

Top module: `flagalu_top`

## Requirements
- R1: After reset the accumulator, hidden operand register, result and all flags are zero.
- R2: `tmp_wr_i` stores `opnd_i` into the hidden operand register on the clock edge. An execute in the same cycle uses the value stored before that edge.
- R3: Operation code 0 (add) and code 1 (add with carry) write acc+tmp(+carry-in) to the accumulator and to `result_o`. CY is the carry out of bit 7. The carry-in is the stored CY when `cin_sel_i`=0 and `cin_ext_i` when `cin_sel_i`=1.
- R4: Code 2 (subtract) and code 3 (subtract with borrow, where the borrow-in is chosen as in R3) write acc-tmp(-borrow) to the accumulator and to `result_o`. CY is set when a borrow occurs.
- R5: Code 7 (compare) sets the flags exactly as subtract does and places the difference on `result_o`. The accumulator is left unchanged.
- R6: Codes 4, 5 and 6 (AND, OR, XOR) write their result to the accumulator and clear CY. AC is set after AND and cleared after OR and XOR.
- R7: Codes 8 and 9 increment and decrement the accumulator. Codes 10 and 11 increment and decrement the hidden operand value and place the result only on `result_o`, leaving the accumulator unchanged. All four leave CY unchanged.
- R8: `flags_o` is {S,Z,AC,P,CY}, with CY at bit 0, P at bit 1, AC at bit 2, Z at bit 3 and S at bit 4. After any operation with a code from 0 to 11, S equals bit 7 of `result_o`, and Z is set exactly when `result_o` is zero.
- R9: After any operation with a code from 0 to 11, P is set when `result_o` holds an even number of ones, and cleared when the count is odd.
- R10: AC is the carry out of bit 3 of the addition that is actually performed. Subtraction adds the inverted operand plus the inverted borrow-in, increment adds 1, and decrement adds 0xFF.
- R11: The accumulator, result and flags change only on an edge with `exe_i` high. Code 12 copies the hidden operand into the accumulator and leaves the flags and result unchanged. Codes 13 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| opnd_i | input | 8 | Operand byte for the hidden register |
| tmp_wr_i | input | 1 | Store `opnd_i` into the hidden register |
| exe_i | input | 1 | Execute `op_i` on this edge |
| cin_sel_i | input | 1 | Carry-in source: 0 stored CY, 1 external |
| cin_ext_i | input | 1 | External carry/borrow-in |
| result_o | output | 8 | Result of the last executed operation |
| acc_o | output | 8 | Accumulator |
| flags_o | output | 5 | {S,Z,AC,P,CY} |

## Verification
A new operand can be stored in the same cycle as an execute. The bench raises both strobes together with different bytes. It checks that the result comes from the old operand, and then that a following execute sees the new one. The stored carry can also feed an add-with-carry in the same cycle that the add rewrites it. The table chains vectors that use `cin_sel_i`=0, and the bench's own model, which tracks the flags, judges the outcome.

// File: rtl/flagalu_pkg.sv
package flagalu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_ADC  = 4'd1,  OP_SUB  = 4'd2,  OP_SBB  = 4'd3,
    OP_AND  = 4'd4,  OP_OR   = 4'd5,  OP_XOR  = 4'd6,  OP_CMP  = 4'd7,
    OP_INCA = 4'd8,  OP_DECA = 4'd9,  OP_INCT = 4'd10, OP_DECT = 4'd11,
    OP_LDA  = 4'd12
  } alu_op_e;

  localparam int FL_CY = 0;
  localparam int FL_P  = 1;
  localparam int FL_AC = 2;
  localparam int FL_Z  = 3;
  localparam int FL_S  = 4;
  localparam int FL_N  = 5;
endpackage

// File: rtl/flagalu_adder.sv
module flagalu_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         hcout_o
);
  localparam int HB = W / 2;
  localparam int UB = W - HB;

  logic [HB:0] lo;
  logic [UB:0] hi;

  always_comb begin
    lo = {1'b0, a_i[HB-1:0]} + {1'b0, b_i[HB-1:0]} + {{HB{1'b0}}, cin_i};
    hi = {1'b0, a_i[W-1:HB]} + {1'b0, b_i[W-1:HB]} + {{UB{1'b0}}, lo[HB]};
  end

  assign sum_o   = {hi[UB-1:0], lo[HB-1:0]};
  assign cout_o  = hi[UB];
  assign hcout_o = lo[HB];
endmodule

// File: rtl/flagalu_status.sv
module flagalu_status #(
  parameter int W = 8
) (
  input  logic [W-1:0] res_i,
  output logic         sign_o,
  output logic         zero_o,
  output logic         even_o
);
  assign sign_o = res_i[W-1];
  assign zero_o = (res_i == '0);
  assign even_o = ~(^res_i);
endmodule

// File: rtl/flagalu_top.sv
module flagalu_top
  import flagalu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] opnd_i,
  input  logic         tmp_wr_i,
  input  logic         exe_i,
  input  logic         cin_sel_i,
  input  logic         cin_ext_i,
  output logic [W-1:0] result_o,
  output logic [W-1:0] acc_o,
  output logic [FL_N-1:0] flags_o
);
  logic [W-1:0]    acc_q, tmp_q, res_q;
  logic [FL_N-1:0] flg_q;

  logic [W-1:0] add_a, add_b, add_sum, res_d;
  logic         add_cin, add_cout, add_hc;
  logic         cin_pick, cy_d, ac_d;
  logic         s_d, z_d, p_d;
  logic         wr_acc, wr_flags;
  alu_op_e      op;

  assign op       = alu_op_e'(op_i);
  assign cin_pick = cin_sel_i ? cin_ext_i : flg_q[FL_CY];

  // operand steering into the shared adder
  always_comb begin
    add_a   = acc_q;
    add_b   = tmp_q;
    add_cin = 1'b0;
    unique case (op)
      OP_ADC:           add_cin = cin_pick;
      OP_SUB, OP_CMP: begin add_b = ~tmp_q; add_cin = 1'b1; end
      OP_SBB:         begin add_b = ~tmp_q; add_cin = ~cin_pick; end
      OP_INCA:        begin add_b = '0; add_cin = 1'b1; end
      OP_DECA:          add_b = '1;
      OP_INCT:        begin add_a = tmp_q; add_b = '0; add_cin = 1'b1; end
      OP_DECT:        begin add_a = tmp_q; add_b = '1; end
      default: ;
    endcase
  end

  flagalu_adder #(.W(W)) u_add (
    .a_i(add_a), .b_i(add_b), .cin_i(add_cin),
    .sum_o(add_sum), .cout_o(add_cout), .hcout_o(add_hc)
  );

  // result and carry-class flags
  always_comb begin
    res_d    = add_sum;
    cy_d     = flg_q[FL_CY];
    ac_d     = add_hc;
    wr_acc   = 1'b0;
    wr_flags = 1'b1;
    unique case (op)
      OP_ADD, OP_ADC:         begin cy_d = add_cout;  wr_acc = 1'b1; end
      OP_SUB, OP_SBB:         begin cy_d = ~add_cout; wr_acc = 1'b1; end
      OP_CMP:                       cy_d = ~add_cout;
      OP_AND: begin res_d = acc_q & tmp_q; cy_d = 1'b0; ac_d = 1'b1; wr_acc = 1'b1; end
      OP_OR:  begin res_d = acc_q | tmp_q; cy_d = 1'b0; ac_d = 1'b0; wr_acc = 1'b1; end
      OP_XOR: begin res_d = acc_q ^ tmp_q; cy_d = 1'b0; ac_d = 1'b0; wr_acc = 1'b1; end
      OP_INCA, OP_DECA:             wr_acc = 1'b1;
      OP_INCT, OP_DECT: ;
      default:                      wr_flags = 1'b0;
    endcase
  end

  flagalu_status #(.W(W)) u_stat (
    .res_i(res_d), .sign_o(s_d), .zero_o(z_d), .even_o(p_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      tmp_q <= '0;
      res_q <= '0;
      flg_q <= '0;
    end else begin
      if (tmp_wr_i) tmp_q <= opnd_i;
      if (exe_i) begin
        if (op == OP_LDA) acc_q <= tmp_q;
        else if (wr_acc)  acc_q <= res_d;
        if (wr_flags) begin
          res_q <= res_d;
          flg_q[FL_S]  <= s_d;
          flg_q[FL_Z]  <= z_d;
          flg_q[FL_AC] <= ac_d;
          flg_q[FL_P]  <= p_d;
          flg_q[FL_CY] <= cy_d;
        end
      end
    end
  end

  assign result_o = res_q;
  assign acc_o    = acc_q;
  assign flags_o  = flg_q;
endmodule

// File: rtl/flagalu_chk.sv
module flagalu_chk
  import flagalu_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   op_i,
  input logic         exe_i,
  input logic [W-1:0] result_o,
  input logic [W-1:0] acc_o,
  input logic [FL_N-1:0] flags_o
);
  logic flag_op;
  assign flag_op = exe_i && (op_i <= 4'd11);

  a_r5_cmp_holds_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_i && op_i == 4'd7) |=> $stable(acc_o));

  a_r7_tmp_incdec_holds_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_i && (op_i == 4'd10 || op_i == 4'd11)) |=> $stable(acc_o));

  a_r7_incdec_keeps_cy: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_i && op_i >= 4'd8 && op_i <= 4'd11) |=> flags_o[FL_CY] == $past(flags_o[FL_CY]));

  a_r6_logic_clears_cy: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_i && op_i >= 4'd4 && op_i <= 4'd6) |=> !flags_o[FL_CY]);

  a_r8_sign_zero: assert property (@(posedge clk) disable iff (!rst_n)
    flag_op |=> (flags_o[FL_S] == result_o[W-1]) && (flags_o[FL_Z] == (result_o == '0)));

  a_r9_parity_even: assert property (@(posedge clk) disable iff (!rst_n)
    flag_op |=> flags_o[FL_P] == ~(^result_o));

  a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !exe_i |=> $stable(flags_o) && $stable(acc_o) && $stable(result_o));

  a_r11_load_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_i && op_i >= 4'd12) |=> $stable(flags_o) && $stable(result_o));
endmodule

bind flagalu_top flagalu_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .op_i(op_i), .exe_i(exe_i),
  .result_o(result_o), .acc_o(acc_o), .flags_o(flags_o)
);

// File: tb/flagalu_top_tb_top.sv
module flagalu_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;
  // {op[3:0], acc[7:0], tmp[7:0], cin_sel, cin_ext}
  localparam logic [21:0] VEC [0:NV-1] = '{
    {4'd0,  8'h3A, 8'h0C, 1'b0, 1'b0},
    {4'd0,  8'hF0, 8'h10, 1'b0, 1'b0},
    {4'd1,  8'h0F, 8'h00, 1'b0, 1'b0},
    {4'd1,  8'h7F, 8'h00, 1'b1, 1'b1},
    {4'd2,  8'h10, 8'h01, 1'b0, 1'b0},
    {4'd2,  8'h05, 8'h09, 1'b0, 1'b0},
    {4'd3,  8'h20, 8'h0F, 1'b0, 1'b0},
    {4'd3,  8'h00, 8'h00, 1'b1, 1'b1},
    {4'd4,  8'hCC, 8'hAA, 1'b0, 1'b0},
    {4'd5,  8'h00, 8'h00, 1'b0, 1'b0},
    {4'd6,  8'hFF, 8'h0F, 1'b0, 1'b0},
    {4'd7,  8'h40, 8'h41, 1'b0, 1'b0},
    {4'd7,  8'h55, 8'h55, 1'b0, 1'b0},
    {4'd8,  8'h0F, 8'h00, 1'b0, 1'b0},
    {4'd9,  8'h00, 8'h00, 1'b0, 1'b0},
    {4'd10, 8'h12, 8'hFF, 1'b0, 1'b0},
    {4'd11, 8'h34, 8'h01, 1'b0, 1'b0},
    {4'd1,  8'h80, 8'h80, 1'b0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] opnd_i = '0;
  logic       tmp_wr_i = 1'b0, exe_i = 1'b0, cin_sel_i = 1'b0, cin_ext_i = 1'b0;
  logic [7:0] result_o, acc_o;
  logic [4:0] flags_o;

  int checks = 0, fails = 0;
  logic [7:0] m_acc = '0, m_tmp = '0, m_res = '0;
  logic [4:0] m_flg = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flagalu_top dut_i (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .opnd_i(opnd_i),
    .tmp_wr_i(tmp_wr_i), .exe_i(exe_i), .cin_sel_i(cin_sel_i),
    .cin_ext_i(cin_ext_i), .result_o(result_o), .acc_o(acc_o), .flags_o(flags_o)
  );

  // reference model of one execute, built from the requirement text
  task automatic model_exe(input int op, input bit sel, input bit ext);
    int a, b, c, r, ac, cy;
    bit upd, wacc;
    a = m_acc; b = m_tmp; c = sel ? int'(ext) : int'(m_flg[0]);
    cy = m_flg[0]; ac = 0; upd = 1; wacc = 1; r = 0;
    case (op)
      0, 1: begin if (op == 0) c = 0; r = a + b + c; cy = (r > 255) ? 1 : 0;
                  ac = ((a % 16) + (b % 16) + c > 15) ? 1 : 0; end
      2, 3, 7: begin if (op != 3) c = 0; r = a - b - c; cy = (r < 0) ? 1 : 0;
                  ac = ((a % 16) + (15 - (b % 16)) + (1 - c) > 15) ? 1 : 0;
                  if (op == 7) wacc = 0; end
      4: begin r = a & b; cy = 0; ac = 1; end
      5: begin r = a | b; cy = 0; ac = 0; end
      6: begin r = a ^ b; cy = 0; ac = 0; end
      8:  begin r = a + 1; ac = (a % 16 == 15) ? 1 : 0; end
      9:  begin r = a - 1; ac = (a % 16 != 0) ? 1 : 0; end
      10: begin r = b + 1; ac = (b % 16 == 15) ? 1 : 0; wacc = 0; end
      11: begin r = b - 1; ac = (b % 16 != 0) ? 1 : 0; wacc = 0; end
      12: begin m_acc = m_tmp; upd = 0; wacc = 0; end
      default: begin upd = 0; wacc = 0; end
    endcase
    if (upd) begin
      r = r & 255;
      m_res = 8'(r);
      if (wacc) m_acc = 8'(r);
      m_flg = {r[7], (r == 0), ac[0], ~(^r[7:0]), cy[0]};
    end
  endtask

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "result", result_o, m_res);
    chk(req, "acc", acc_o, m_acc);
    chk(req, "flags", {3'b0, flags_o}, {3'b0, m_flg});
  endtask

  // one cycle: drive at negedge, edge captures, next negedge returns
  task automatic step(input int op, input bit wr, input logic [7:0] d,
                      input bit ex, input bit sel, input bit ext);
    op_i = 4'(op); tmp_wr_i = wr; opnd_i = d; exe_i = ex;
    cin_sel_i = sel; cin_ext_i = ext;
    @(negedge clk);
    if (ex) model_exe(op, sel, ext);
    if (wr) m_tmp = d;
    tmp_wr_i = 1'b0; exe_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1", "result", result_o, 8'h00);
    chk("R1", "acc", acc_o, 8'h00);
    chk("R1", "flags", {3'b0, flags_o}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      step(12, 1, VEC[i][17:10], 0, 0, 0);
      step(12, 0, 8'h00, 1, 0, 0);
      step(0, 1, VEC[i][9:2], 0, 0, 0);
      step(int'(VEC[i][21:18]), 0, 8'h00, 1, VEC[i][1], VEC[i][0]);
      chk("R3-R10 vec", "result", result_o, m_res);
      chk("R8 vec", "acc", acc_o, m_acc);
      chk("R9 vec", "flags", {3'b0, flags_o}, {3'b0, m_flg});
    end

    // R2: write and execute in the same cycle
    step(12, 1, 8'h21, 0, 0, 0);
    step(12, 0, 8'h00, 1, 0, 0);
    step(0, 1, 8'h01, 0, 0, 0);
    step(0, 1, 8'h10, 1, 0, 0);
    chk("R2", "result old operand", result_o, 8'h22);
    step(0, 0, 8'h00, 1, 0, 0);
    chk("R2", "result new operand", result_o, 8'h32);
    chk_all("R2");

    // R11: idle cycles and unused codes change nothing
    step(12, 1, 8'h99, 0, 0, 0);
    repeat (3) step(2, 0, 8'h00, 0, 0, 0);
    chk_all("R11 idle");
    step(14, 0, 8'h00, 1, 0, 0);
    chk_all("R11 unused code");
    step(12, 0, 8'h00, 1, 0, 0);
    chk("R11", "load acc", acc_o, 8'h99);
    chk_all("R11 load");

    // R7: temp increment leaves acc, CY kept set
    step(0, 1, 8'hFF, 0, 0, 0);
    step(0, 0, 8'h00, 1, 0, 0);
    step(10, 0, 8'h00, 1, 0, 0);
    chk("R7", "cy kept", {7'b0, flags_o[0]}, 8'h01);
    chk("R7", "result wrap", result_o, 8'h00);
    chk_all("R7");

    // R1: reset mid-run clears state
    rst_n = 1'b0;
    @(negedge clk);
    m_acc = '0; m_tmp = '0; m_res = '0; m_flg = '0;
    chk_all("R1 rerun");
    rst_n = 1'b1;
    @(negedge clk);
    step(0, 0, 8'h00, 1, 0, 0);
    chk_all("R1 tmp zero");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule